// File: doc/BRIEF.md
# Two-Pin Bidirectional Port with Bus-Access Strobes

This block gives an 8-bit CPU bus control over two general-purpose pins, called A and B. Each pin has a tri-state driver with its own output value and output-enable, plus an input level that the CPU can read back. Two registers set the pins. One is write-only and holds each pin's direction and output source. The other latches the data bits on a write and returns the live pin levels on a read. A pin set as an output drives high or low. A pin set as an input has its driver released. No other drive state exists.

The block also snoops the bus. While the CPU reads anywhere in a RAM window, pin A carries the inverse of the bus clock phase, which makes it an active-low chip enable. While the CPU writes to one particular address, pin B carries that strobe in the same way. The strobe takes priority over the register settings for as long as the access lasts. Normal control returns when the access ends. Register writes take effect on the falling edge of the bus clock phase, which is sampled in the system clock domain. A synchronous reset restores the defaults.

Top module: `gpio2_strobe_ctrl`

## Requirements
- R1: While reset is held and on the cycle after it, both pins have their drivers released (`pin_oe` = 00) and both latched data bits are 0. If a pin is then made an output with the data source selected, it drives 0.
- R2: The config register is at address 0x5207. It is captured on the first system clock edge that sees `m2` low after a sampled high, provided `bus_wr` is high and the address matches. Bit 7 sets B's direction and bit 6 sets A's direction (1 = input, 0 = output). Bit 1 sets B's source and bit 0 sets A's source (1 = force high, 0 = latched data).
- R3: A write to 0x5208, captured the same way, latches bit 6 as A's data and bit 7 as B's data. A pin drives its data bit only when its direction bit and source bit are both 0.
- R4: A pin whose direction is output and whose source bit is 1 drives 1, whatever its latched data bit holds.
- R5: A pin whose direction bit is 1 has its driver released (`pin_oe` low), unless a strobe is active on it.
- R6: When `bus_rd` is high and the address is 0x5208, `bus_rdata` returns `pin_in[0]` on bit 6 and `pin_in[1]` on bit 7, and 0 on bits 5:0. Every other address returns 0x00.
- R7: A write has no effect on the registers when `m2` does not fall, when the address matches neither register, or when only `bus_rd` is high.
- R8: While `bus_rd` is high and the address is within 0x5800–0x5BFF, pin A is driven (`pin_oe[0]` = 1) with the inverse of `m2`. At 0x57FF and 0x5C00 the pin keeps its register-controlled state.
- R9: While `bus_wr` is high and the address is 0x5800, pin B is driven with the inverse of `m2`. At 0x5801 it is not.
- R10: When a strobe access ends, the pin returns at once to the state its registers select.
- R11: The config register is write-only: a read of 0x5207 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset; held while the bus-clock-stop detector reports a reset condition |
| m2 | input | 1 | Bus clock phase; high during the data part of a CPU cycle |
| bus_rd | input | 1 | High while a CPU read cycle is in progress |
| bus_wr | input | 1 | High while a CPU write cycle is in progress |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data; nonzero only for a read of the status register |
| pin_in | input | 2 | Input levels of pins A (bit 0) and B (bit 1) |
| pin_out | output | 2 | Output values of pins A (bit 0) and B (bit 1) |
| pin_oe | output | 2 | Driver enables of pins A (bit 0) and B (bit 1); 0 releases the pin |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address, register addresses 0x5207 and 0x5208, a 1024-byte read window starting at 0x5800, and a write strobe at 0x5800. With those values the window edges 0x57FF, 0x5800, 0x5BFF and 0x5C00 can be reached directly, along with the single-address write strobe and its neighbour 0x5801. The bench also covers writes that are missing the falling `m2` edge, writes to the wrong address, and a strobe laid over a pin that its registers hold as an input or as a low output.

// File: rtl/gpio2_pkg.sv
package gpio2_pkg;

    localparam int NPINS   = 2;
    // bit positions within the two registers; pin p uses LSB + p
    localparam int DIR_LSB = 6;
    localparam int SRC_LSB = 0;
    localparam int DAT_LSB = 6;

    typedef struct packed {
        logic dir_in;    // 1: driver released
        logic force_hi;  // 1: output forced high
        logic data;      // latched output value
    } pin_cfg_t;

    typedef enum logic [1:0] {
        SRC_RELEASE,
        SRC_STROBE,
        SRC_FORCE,
        SRC_DATA
    } pin_src_e;

    function automatic pin_src_e pick_src(input logic strobe, input pin_cfg_t c);
        if (strobe)        return SRC_STROBE;
        else if (c.dir_in) return SRC_RELEASE;
        else if (c.force_hi) return SRC_FORCE;
        else               return SRC_DATA;
    endfunction

endpackage

// File: rtl/gpio2_regs.sv
module gpio2_regs
    import gpio2_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 16'h5207,
    parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h5208
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    m2,
    input  logic                    bus_rd,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    input  logic [NPINS-1:0]        pin_in,
    output logic [DATA_W-1:0]       bus_rdata,
    output pin_cfg_t [NPINS-1:0]    cfg_o
);

    logic m2_q;
    logic m2_fall;
    logic cfg_hit, dat_hit;
    pin_cfg_t [NPINS-1:0] cfg_q;

    assign m2_fall = m2_q & ~m2;
    assign cfg_hit = bus_wr & m2_fall & (bus_addr == CFG_ADDR);
    assign dat_hit = bus_wr & m2_fall & (bus_addr == DAT_ADDR);

    always_ff @(posedge clk) begin
        if (rst) m2_q <= 1'b0;
        else     m2_q <= m2;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[p] <= '{dir_in: 1'b1, force_hi: 1'b0, data: 1'b0};
            end else begin
                if (cfg_hit) begin
                    cfg_q[p].dir_in   <= bus_wdata[DIR_LSB + p];
                    cfg_q[p].force_hi <= bus_wdata[SRC_LSB + p];
                end
                if (dat_hit) cfg_q[p].data <= bus_wdata[DAT_LSB + p];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && bus_addr == DAT_ADDR) begin
            for (int p = 0; p < NPINS; p++) bus_rdata[DAT_LSB + p] = pin_in[p];
        end
    end

    assign cfg_o = cfg_q;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DAT_LSB-1:SRC_LSB+NPINS];

    // R1: defaults on the cycle after reset
    p_reset_defaults_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q[0].dir_in && cfg_q[1].dir_in && !cfg_q[0].data && !cfg_q[1].data));

    // R7: register contents move only after a qualified write on a falling m2
    p_cfg_needs_fall_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> $past(bus_wr && !m2 &&
            (bus_addr == CFG_ADDR || bus_addr == DAT_ADDR)));

    // R6, R11: unused read bits stay zero; config register is not readable
    p_rdata_unused_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == CFG_ADDR || !bus_rd) |-> bus_rdata == '0);

endmodule

// File: rtl/gpio2_strobe.sv
module gpio2_strobe
    import gpio2_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h5800,
    parameter int WIN_SIZE = 1024,
    parameter logic [ADDR_W-1:0] WSTB_ADDR = 16'h5800
) (
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NPINS-1:0]  strobe
);

    localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(WIN_BASE + WIN_SIZE - 1);

    logic in_win;
    assign in_win    = (bus_addr >= WIN_BASE) && (bus_addr <= WIN_LAST);
    assign strobe[0] = bus_rd & in_win;
    assign strobe[1] = bus_wr & (bus_addr == WSTB_ADDR);

endmodule

// File: rtl/gpio2_pin.sv
module gpio2_pin
    import gpio2_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     m2,
    input  logic     strobe,
    input  pin_cfg_t cfg,
    output logic     out,
    output logic     oe
);

    pin_src_e src;
    assign src = pick_src(strobe, cfg);

    always_comb begin
        unique case (src)
            SRC_STROBE:  begin oe = 1'b1; out = ~m2;      end
            SRC_FORCE:   begin oe = 1'b1; out = 1'b1;     end
            SRC_DATA:    begin oe = 1'b1; out = cfg.data; end
            default:     begin oe = 1'b0; out = 1'b0;     end
        endcase
    end

    // R8 / R9: a strobe drives the inverse bus clock phase
    p_strobe_drive_r8: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (oe && out == !m2));

    // R5: an input pin without strobe is released
    p_input_released_r5: assert property (@(posedge clk) disable iff (rst)
        (!strobe && cfg.dir_in) |-> !oe);

    // R4: forced-high output drives 1
    p_force_high_r4: assert property (@(posedge clk) disable iff (rst)
        (!strobe && !cfg.dir_in && cfg.force_hi) |-> (oe && out));

endmodule

// File: rtl/gpio2_strobe_ctrl.sv
module gpio2_strobe_ctrl
    import gpio2_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'h5207,
    parameter logic [ADDR_W-1:0] DAT_ADDR  = 16'h5208,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 16'h5800,
    parameter int                WIN_SIZE  = 1024,
    parameter logic [ADDR_W-1:0] WSTB_ADDR = 16'h5800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m2,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        pin_in,
    output logic [1:0]        pin_out,
    output logic [1:0]        pin_oe
);

    pin_cfg_t [NPINS-1:0] cfg;
    logic     [NPINS-1:0] strobe;

    gpio2_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CFG_ADDR(CFG_ADDR), .DAT_ADDR(DAT_ADDR)
    ) u_regs (
        .clk(clk), .rst(rst), .m2(m2),
        .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .pin_in(pin_in), .bus_rdata(bus_rdata), .cfg_o(cfg)
    );

    gpio2_strobe #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE),
        .WIN_SIZE(WIN_SIZE), .WSTB_ADDR(WSTB_ADDR)
    ) u_strobe (
        .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .strobe(strobe)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        gpio2_pin u_pin (
            .clk(clk), .rst(rst), .m2(m2),
            .strobe(strobe[p]), .cfg(cfg[p]),
            .out(pin_out[p]), .oe(pin_oe[p])
        );
    end

    // R10: outside any access no strobe can be active, so pins follow registers
    p_no_strobe_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd && !bus_wr && !cfg[0].dir_in && !cfg[0].force_hi) |-> (pin_oe[0] && pin_out[0] == cfg[0].data));

endmodule

// File: tb/sim_gpio2_strobe_ctrl.sv
module sim_gpio2_strobe_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m2 = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [1:0]  pin_in = 2'b00;
    logic [1:0]  pin_out;
    logic [1:0]  pin_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio2_strobe_ctrl u0 (
        .clk(clk), .rst(rst), .m2(m2),
        .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_pins(input string req, input logic [1:0] eoe, input logic [1:0] eout);
        check({req, " oe"}, {6'b0, pin_oe}, {6'b0, eoe});
        check({req, " out"}, {6'b0, pin_out & eoe}, {6'b0, eout & eoe});
    endtask

    // full bus write: m2 high for a cycle, then falls
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; m2 = 1'b1;
        @(negedge clk);
        m2 = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0000;
        @(negedge clk);
    endtask

    task automatic read_at(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check_pins("R1 reset released", 2'b00, 2'b00);
        pin_in = 2'b00;
        read_at(16'h5208, d);
        check("R6 reset read", d, 8'h00);
        bus_write(16'h5207, 8'h00);
        check_pins("R1 data default 0", 2'b11, 2'b00);
    endtask

    task automatic t_data;
        bus_write(16'h5208, 8'h40);
        check_pins("R3 A data", 2'b11, 2'b01);
        bus_write(16'h5208, 8'h80);
        check_pins("R3 B data", 2'b11, 2'b10);
        bus_write(16'h5208, 8'hC0);
        check_pins("R3 both data", 2'b11, 2'b11);
        bus_write(16'h5208, 8'h3F);
        check_pins("R3 low bits ignored", 2'b11, 2'b00);
    endtask

    task automatic t_force;
        bus_write(16'h5207, 8'h01);
        check_pins("R4 A forced R2", 2'b11, 2'b01);
        bus_write(16'h5207, 8'h02);
        check_pins("R4 B forced R2", 2'b11, 2'b10);
        bus_write(16'h5207, 8'h00);
        check_pins("R2 source back to data", 2'b11, 2'b00);
    endtask

    task automatic t_dir;
        bus_write(16'h5207, 8'h40);
        check_pins("R5 A input", 2'b10, 2'b00);
        bus_write(16'h5207, 8'h80);
        check_pins("R5 B input", 2'b01, 2'b00);
        bus_write(16'h5207, 8'hC3);
        check_pins("R5 both input", 2'b00, 2'b00);
    endtask

    task automatic t_read;
        logic [7:0] d;
        pin_in = 2'b01; read_at(16'h5208, d); check("R6 A level", d, 8'h40);
        pin_in = 2'b10; read_at(16'h5208, d); check("R6 B level", d, 8'h80);
        pin_in = 2'b11; read_at(16'h5208, d); check("R6 both", d, 8'hC0);
        read_at(16'h5207, d); check("R11 write-only", d, 8'h00);
        read_at(16'h5209, d); check("R6 other addr", d, 8'h00);
        pin_in = 2'b00;
    endtask

    task automatic t_ignore;
        bus_write(16'h5207, 8'h00);
        bus_write(16'h5208, 8'h00);
        // write without m2 falling
        @(negedge clk);
        bus_addr = 16'h5207; bus_wdata = 8'hC3; bus_wr = 1'b1; m2 = 1'b0;
        repeat (3) @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        check_pins("R7 no m2 fall", 2'b11, 2'b00);
        bus_write(16'h5209, 8'hC3);
        check_pins("R7 wrong address", 2'b11, 2'b00);
        // read cycle with falling m2 must not write
        @(negedge clk);
        bus_addr = 16'h5208; bus_wdata = 8'hC0; bus_rd = 1'b1; m2 = 1'b1;
        @(negedge clk); m2 = 1'b0;
        @(negedge clk); bus_rd = 1'b0;
        @(negedge clk);
        check_pins("R7 read does not write", 2'b11, 2'b00);
    endtask

    task automatic strobe_probe(input string req, input logic rd, input logic [15:0] a,
                                input logic [1:0] eoe_hi, input logic [1:0] eout_hi,
                                input logic [1:0] eoe_lo, input logic [1:0] eout_lo);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = ~rd; bus_wdata = 8'h00; m2 = 1'b1;
        #5 check_pins({req, " m2 high"}, eoe_hi, eout_hi);
        @(negedge clk);
        m2 = 1'b0;
        #5 check_pins({req, " m2 low"}, eoe_lo, eout_lo);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic t_strobe;
        bus_write(16'h5207, 8'hC0);
        strobe_probe("R8 read 5800", 1'b1, 16'h5800, 2'b01, 2'b00, 2'b01, 2'b01);
        strobe_probe("R8 read 5BFF", 1'b1, 16'h5BFF, 2'b01, 2'b00, 2'b01, 2'b01);
        strobe_probe("R8 read 57FF", 1'b1, 16'h57FF, 2'b00, 2'b00, 2'b00, 2'b00);
        strobe_probe("R8 read 5C00", 1'b1, 16'h5C00, 2'b00, 2'b00, 2'b00, 2'b00);
        strobe_probe("R9 write 5800", 1'b0, 16'h5800, 2'b10, 2'b00, 2'b10, 2'b10);
        strobe_probe("R9 write 5801", 1'b0, 16'h5801, 2'b00, 2'b00, 2'b00, 2'b00);
        #5 check_pins("R10 after strobe inputs", 2'b00, 2'b00);
    endtask

    task automatic t_resume;
        bus_write(16'h5207, 8'h00);
        bus_write(16'h5208, 8'h00);
        strobe_probe("R10 read over low output", 1'b1, 16'h5A00, 2'b11, 2'b00, 2'b11, 2'b01);
        #5 check_pins("R10 resumes low", 2'b11, 2'b00);
        bus_write(16'h5207, 8'h02);
        strobe_probe("R10 write over forced B", 1'b0, 16'h5800, 2'b11, 2'b00, 2'b11, 2'b10);
        #5 check_pins("R10 resumes forced", 2'b11, 2'b10);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #5 check_pins("R1 during reset", 2'b00, 2'b00);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_data();
        t_force();
        t_dir();
        t_read();
        t_ignore();
        t_strobe();
        t_resume();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule